// File: doc/BRIEF.md
# Fractional-N Ratio Selector

This block produces the ratio word that steers a fractional-N frequency synthesizer. It keeps four user ratio words in a small synchronous-read store and picks one of them. In static operation two mode pins choose the word. In dynamic operation a 2-bit lock index chooses it. The chosen word is read as 12.20 or 20.12 unsigned fixed point and widened to a common 32.32 word. It is then scaled by a power-of-two modifier and by a correction for the reference input divider. The result is the effective (static) ratio.

A final stage passes to the synthesizer either that static ratio or a 32.32 dynamic ratio supplied by an external digital PLL. The source can be set by hand with a register bit. It can also be chosen automatically from whether edges are seen on the frequency reference clock input. A force pin puts the block into hand selection whatever the mode bit says.

Top module: `fracn_ratio_sel`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` in slot `wr_idx_i`. A later selection of that slot uses the newest word written.
- R2: With `dyn_mode_i` low, the slot index is `mode_pins_i` and `lock_idx_i` has no effect on the outputs.
- R3: With `dyn_mode_i` high, the slot index is `lock_idx_i` and `mode_pins_i` has no effect on the outputs.
- R4: With `dyn_mode_i` low, the word is always read as 12.20 (12 integer bits, 20 fraction bits) and `fmt_wide_i` has no effect. At modifier 00 and divider code 10, `eff_ratio_o` equals the word shifted left by 12 (32.32 result).
- R5: With `dyn_mode_i` high, `fmt_wide_i`=0 reads the word as 12.20 and `fmt_wide_i`=1 reads it as 20.12 (word shifted left by 20 into 32.32).
- R6: `rmod_sel_i` scales the ratio exactly: 00 gives x1, 01 gives x2, 10 gives x4, and 11 gives x1/2 (a right shift that drops the lowest bit).
- R7: `refdiv_sel_i` multiplies the ratio to make up for the reference divider: 00 (divide by 4) gives x4, 01 (divide by 2) gives x2, 10 and the reserved code 11 give x1. Modifier and correction combine into one exact product.
- R8: In hand selection (`manual_src_i` or `force_manual_i` high), `use_dynamic_o` equals `src_dyn_bit_i`. `fracn_word_o` is `dpll_ratio_i` when it is 1 and `eff_ratio_o` when it is 0.
- R9: In automatic selection (both low), `use_dynamic_o` follows `ref_present_o`. Raising `force_manual_i` switches to hand selection.
- R10: `ref_present_o` rises at the end of a 1024-cycle window in which a rising edge of `ref_clk_i` was seen. It stays high through one empty window and falls at the end of the second consecutive empty window.
- R11: All outputs are registered. `eff_ratio_o` reflects inputs held before 2 clock edges. `fracn_word_o` and `use_dynamic_o` reflect inputs held before 3 edges.
- R12: During synchronous active-high reset, all four outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Store write strobe |
| wr_idx_i | input | 2 | Slot written |
| wr_data_i | input | 32 | Ratio word written |
| dyn_mode_i | input | 1 | 1 selects dynamic operation |
| mode_pins_i | input | 2 | Slot index in static operation |
| lock_idx_i | input | 2 | Slot index in dynamic operation |
| fmt_wide_i | input | 1 | Dynamic only: 1 reads the word as 20.12 |
| rmod_sel_i | input | 2 | Ratio modifier code |
| refdiv_sel_i | input | 2 | Reference divider code |
| manual_src_i | input | 1 | 1 selects hand source selection |
| src_dyn_bit_i | input | 1 | Hand selection: 1 takes the dynamic ratio |
| force_manual_i | input | 1 | Forces hand source selection |
| ref_clk_i | input | 1 | Frequency reference clock, asynchronous |
| dpll_ratio_i | input | 64 | Dynamic 32.32 ratio from the digital PLL |
| eff_ratio_o | output | 64 | Effective static ratio, 32.32 |
| fracn_word_o | output | 64 | Ratio word sent to the synthesizer |
| use_dynamic_o | output | 1 | 1 when the dynamic ratio is in use |
| ref_present_o | output | 1 | Reference clock activity detected |

## Verification
The bench changes every input half a period away from the rising edge and samples half a period after an edge. The effective ratio is due two edges after its inputs change, and the synthesizer word and source flag are due three edges after. A dedicated check samples one edge early and confirms the old value is still shown, so an extra or a missing register is caught. The sweep waits four edges per configuration. The presence flag depends on the 1024-cycle window phase, so it is sampled only at points where every possible phase gives the same answer: 2100 cycles after edges start, and 1000 and 3200 cycles after they stop.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [1:0] {
    RMOD_X1   = 2'b00,
    RMOD_X2   = 2'b01,
    RMOD_X4   = 2'b10,
    RMOD_HALF = 2'b11
  } rmod_e;

  // left shift contributed by the modifier (the halving code contributes none)
  function automatic logic [2:0] rmod_up(input logic [1:0] code);
    case (code)
      RMOD_X2: rmod_up = 3'd1;
      RMOD_X4: rmod_up = 3'd2;
      default: rmod_up = 3'd0;
    endcase
  endfunction

  // left shift that undoes the reference pre-divider
  function automatic logic [2:0] rdiv_up(input logic [1:0] code);
    case (code)
      2'b00:   rdiv_up = 3'd2;
      2'b01:   rdiv_up = 3'd1;
      default: rdiv_up = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/frs_ratio_store.sv
module frs_ratio_store #(
  parameter int NUM_RATIOS = 4,
  parameter int RATIO_W    = 32,
  localparam int IDX_W     = $clog2(NUM_RATIOS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [RATIO_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [RATIO_W-1:0] rd_word_o
);

  logic [RATIO_W-1:0] slots [NUM_RATIOS];

  // write port, no reset so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en_i) slots[wr_idx_i] <= wr_data_i;
  end

  // registered read port (read-before-write on a colliding address)
  always_ff @(posedge clk) begin
    if (rst) rd_word_o <= '0;
    else     rd_word_o <= slots[rd_idx_i];
  end

endmodule

// File: rtl/frs_ratio_scale.sv
module frs_ratio_scale
  import frs_pkg::*;
#(
  parameter int RATIO_W  = 32,
  parameter int FRAC_A   = 20,
  parameter int FRAC_B   = 12,
  parameter int OUT_W    = 64,
  parameter int OUT_FRAC = 32,
  localparam int SH_A    = OUT_FRAC - FRAC_A,
  localparam int SH_B    = OUT_FRAC - FRAC_B,
  localparam int MAX_UP  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] word_i,
  input  logic               fmt_b_i,
  input  logic [1:0]         rmod_i,
  input  logic [1:0]         rdiv_i,
  output logic [OUT_W-1:0]   ratio_o
);

  logic [OUT_W-1:0] base;
  logic [OUT_W-1:0] scaled;
  logic [2:0]       up_r;
  logic [2:0]       up_d;
  logic             halve;

  always_comb begin
    base  = fmt_b_i ? (OUT_W'(word_i) << SH_B) : (OUT_W'(word_i) << SH_A);
    up_r  = rmod_up(rmod_i);
    up_d  = rdiv_up(rdiv_i);
    halve = (rmod_i == RMOD_HALF);
    if (halve) begin
      if (up_d == 3'd0) scaled = base >> 1;
      else              scaled = base << (up_d - 3'd1);
    end else begin
      scaled = base << (up_r + up_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ratio_o <= '0;
    else     ratio_o <= scaled;
  end

  // the widened word must leave room for the largest left shift
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!halve && (up_r + up_d) != 3'd0) |-> ((base >> (OUT_W - MAX_UP)) == '0)); // R6

  // the halving code with divide-by-1 correction yields half the previous base
  AST_HALF_EXACT: assert property (@(posedge clk) disable iff (rst)
    (halve && up_d == 3'd0) |=> (ratio_o == ($past(base) >> 1))); // R6

endmodule

// File: rtl/frs_clk_sense.sv
module frs_clk_sense #(
  parameter int WIN_CYC  = 1024,
  parameter int MISS_WIN = 2,
  localparam int CW      = $clog2(WIN_CYC),
  localparam int MW      = $clog2(MISS_WIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic present_o
);

  logic [2:0]    sync_q;
  logic          ref_edge;
  logic [CW-1:0] win_cnt;
  logic          win_end;
  logic          seen_q;
  logic [MW-1:0] miss_q;

  always_comb begin
    ref_edge = sync_q[1] & ~sync_q[2];
    win_end  = (win_cnt == CW'(WIN_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      win_cnt   <= '0;
      seen_q    <= 1'b0;
      miss_q    <= '0;
      present_o <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], ref_i};
      win_cnt <= win_end ? '0 : win_cnt + CW'(1);
      if (win_end) begin
        seen_q <= 1'b0;
        if (seen_q || ref_edge) begin
          present_o <= 1'b1;
          miss_q    <= '0;
        end else if (miss_q >= MW'(MISS_WIN - 1)) begin
          present_o <= 1'b0;
        end else begin
          miss_q <= miss_q + MW'(1);
        end
      end else if (ref_edge) begin
        seen_q <= 1'b1;
      end
    end
  end

  AST_PRESENT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(present_o) |-> $past(win_end)); // R10

  AST_PRESENT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(present_o) |-> ($past(win_end) && !$past(seen_q))); // R10

endmodule

// File: rtl/fracn_ratio_sel.sv
module fracn_ratio_sel
  import frs_pkg::*;
#(
  parameter int NUM_RATIOS = 4,
  parameter int RATIO_W    = 32,
  parameter int FRAC_A     = 20,
  parameter int FRAC_B     = 12,
  parameter int OUT_W      = 64,
  parameter int OUT_FRAC   = 32,
  parameter int WIN_CYC    = 1024,
  parameter int MISS_WIN   = 2,
  localparam int IDX_W     = $clog2(NUM_RATIOS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [RATIO_W-1:0] wr_data_i,
  input  logic               dyn_mode_i,
  input  logic [IDX_W-1:0]   mode_pins_i,
  input  logic [IDX_W-1:0]   lock_idx_i,
  input  logic               fmt_wide_i,
  input  logic [1:0]         rmod_sel_i,
  input  logic [1:0]         refdiv_sel_i,
  input  logic               manual_src_i,
  input  logic               src_dyn_bit_i,
  input  logic               force_manual_i,
  input  logic               ref_clk_i,
  input  logic [OUT_W-1:0]   dpll_ratio_i,
  output logic [OUT_W-1:0]   eff_ratio_o,
  output logic [OUT_W-1:0]   fracn_word_o,
  output logic               use_dynamic_o,
  output logic               ref_present_o
);

  logic [IDX_W-1:0]   rd_idx;
  logic               manual_sel;
  logic [RATIO_W-1:0] word_a;
  logic               fmt_a;
  logic [1:0]         rmod_a;
  logic [1:0]         rdiv_a;
  logic               src_a;
  logic               src_b;
  logic [OUT_W-1:0]   dpll_a;
  logic [OUT_W-1:0]   dpll_b;
  logic [2:0]         pipe_cnt;

  always_comb begin
    rd_idx     = dyn_mode_i ? lock_idx_i : mode_pins_i;
    manual_sel = manual_src_i | force_manual_i;
  end

  frs_ratio_store #(
    .NUM_RATIOS (NUM_RATIOS),
    .RATIO_W    (RATIO_W)
  ) store_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_idx),
    .rd_word_o (word_a)
  );

  frs_clk_sense #(
    .WIN_CYC  (WIN_CYC),
    .MISS_WIN (MISS_WIN)
  ) sense_i (
    .clk       (clk),
    .rst       (rst),
    .ref_i     (ref_clk_i),
    .present_o (ref_present_o)
  );

  // stage A: settings aligned with the store read
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_a  <= 1'b0;
      rmod_a <= '0;
      rdiv_a <= '0;
      src_a  <= 1'b0;
      dpll_a <= '0;
    end else begin
      fmt_a  <= dyn_mode_i & fmt_wide_i;
      rmod_a <= rmod_sel_i;
      rdiv_a <= refdiv_sel_i;
      src_a  <= manual_sel ? src_dyn_bit_i : ref_present_o;
      dpll_a <= dpll_ratio_i;
    end
  end

  // stage B: effective ratio
  frs_ratio_scale #(
    .RATIO_W  (RATIO_W),
    .FRAC_A   (FRAC_A),
    .FRAC_B   (FRAC_B),
    .OUT_W    (OUT_W),
    .OUT_FRAC (OUT_FRAC)
  ) scale_i (
    .clk     (clk),
    .rst     (rst),
    .word_i  (word_a),
    .fmt_b_i (fmt_a),
    .rmod_i  (rmod_a),
    .rdiv_i  (rdiv_a),
    .ratio_o (eff_ratio_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_b  <= 1'b0;
      dpll_b <= '0;
    end else begin
      src_b  <= src_a;
      dpll_b <= dpll_a;
    end
  end

  // stage C: registered source mux, glitch-free select
  always_ff @(posedge clk) begin
    if (rst) begin
      fracn_word_o  <= '0;
      use_dynamic_o <= 1'b0;
    end else begin
      fracn_word_o  <= src_b ? dpll_b : eff_ratio_o;
      use_dynamic_o <= src_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  pipe_cnt <= '0;
    else if (pipe_cnt != 3'd4) pipe_cnt <= pipe_cnt + 3'd1;
  end

  AST_MANUAL_SRC: assert property (@(posedge clk) disable iff (rst)
    (pipe_cnt == 3'd4 && $past(manual_sel, 3)) |-> (use_dynamic_o == $past(src_dyn_bit_i, 3))); // R8

  AST_AUTO_SRC: assert property (@(posedge clk) disable iff (rst)
    (pipe_cnt == 3'd4 && !$past(manual_sel, 3)) |-> (use_dynamic_o == $past(ref_present_o, 3))); // R9

  AST_DYN_WORD: assert property (@(posedge clk) disable iff (rst)
    (pipe_cnt == 3'd4 && use_dynamic_o) |-> (fracn_word_o == $past(dpll_ratio_i, 3))); // R8

endmodule

// File: tb/fracn_ratio_sel_tb_top.sv
module fracn_ratio_sel_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en_i;
  logic [1:0]  wr_idx_i;
  logic [31:0] wr_data_i;
  logic        dyn_mode_i;
  logic [1:0]  mode_pins_i;
  logic [1:0]  lock_idx_i;
  logic        fmt_wide_i;
  logic [1:0]  rmod_sel_i;
  logic [1:0]  refdiv_sel_i;
  logic        manual_src_i;
  logic        src_dyn_bit_i;
  logic        force_manual_i;
  logic        ref_clk_i = 1'b0;
  logic [63:0] dpll_ratio_i;
  logic [63:0] eff_ratio_o;
  logic [63:0] fracn_word_o;
  logic        use_dynamic_o;
  logic        ref_present_o;

  int checks = 0;
  int errors = 0;
  logic ref_run = 1'b0;
  logic done = 1'b0;
  logic [31:0] words [4];
  localparam logic [63:0] DPLL = 64'h1234_5678_9ABC_DEF0;

  always #10 clk = ~clk;

  initial forever begin
    #70;
    if (ref_run) ref_clk_i = ~ref_clk_i;
  end

  fracn_ratio_sel dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .dyn_mode_i(dyn_mode_i), .mode_pins_i(mode_pins_i), .lock_idx_i(lock_idx_i),
    .fmt_wide_i(fmt_wide_i), .rmod_sel_i(rmod_sel_i), .refdiv_sel_i(refdiv_sel_i),
    .manual_src_i(manual_src_i), .src_dyn_bit_i(src_dyn_bit_i), .force_manual_i(force_manual_i),
    .ref_clk_i(ref_clk_i), .dpll_ratio_i(dpll_ratio_i), .eff_ratio_o(eff_ratio_o),
    .fracn_word_o(fracn_word_o), .use_dynamic_o(use_dynamic_o), .ref_present_o(ref_present_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // value / 2^frac scaled to 32.32, times modifier and divider correction
  function automatic logic [63:0] expect_eff(input logic [31:0] w, input bit wide,
                                             input int rm, input int rd);
    logic [63:0] base;
    int num2;
    int md;
    base = wide ? ({32'b0, w} * 64'd1048576) : ({32'b0, w} * 64'd4096);
    num2 = (rm == 0) ? 2 : (rm == 1) ? 4 : (rm == 2) ? 8 : 1;
    md   = (rd == 0) ? 4 : (rd == 1) ? 2 : 1;
    return (base * 64'(num2) * 64'(md)) / 64'd2;
  endfunction

  task automatic write_word(input int idx, input logic [31:0] w);
    wr_en_i = 1'b1; wr_idx_i = 2'(idx); wr_data_i = w;
    tick(1);
    wr_en_i = 1'b0;
    words[idx] = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
    dyn_mode_i = 1'b0; mode_pins_i = '0; lock_idx_i = '0; fmt_wide_i = 1'b0;
    rmod_sel_i = '0; refdiv_sel_i = 2'b10; manual_src_i = 1'b1; src_dyn_bit_i = 1'b0;
    force_manual_i = 1'b0; dpll_ratio_i = DPLL;
    tick(3);
    // R12 reset state
    chk("R12 eff", eff_ratio_o, 64'd0);
    chk("R12 fracn", fracn_word_o, 64'd0);
    chk("R12 use_dyn", {63'd0, use_dynamic_o}, 64'd0);
    chk("R12 present", {63'd0, ref_present_o}, 64'd0);
    rst = 1'b0;
    tick(1);

    write_word(0, 32'h0010_0000);
    write_word(1, 32'hFFFF_FFFF);
    write_word(2, 32'h0234_5678);
    write_word(3, 32'h8000_0001);

    // sweep: static R2 R4, dynamic R3 R5, with R1 R6 R7
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 4; i++)
        for (int f = 0; f < 2; f++)
          for (int r = 0; r < 4; r++)
            for (int v = 0; v < 4; v++) begin
              logic [63:0] e;
              dyn_mode_i = d[0];
              mode_pins_i = d[0] ? ~2'(i) : 2'(i);
              lock_idx_i  = d[0] ? 2'(i) : ~2'(i);
              fmt_wide_i = f[0]; rmod_sel_i = 2'(r); refdiv_sel_i = 2'(v);
              tick(4);
              e = expect_eff(words[i], (d == 1) && (f == 1), r, v);
              if (d == 0) begin
                chk("R1 R2 R4 R6 R7 eff", eff_ratio_o, e);
                chk("R8 R2 static fracn", fracn_word_o, e);
              end else begin
                chk("R1 R3 R5 R6 R7 eff", eff_ratio_o, e);
                chk("R8 R3 dynamic fracn", fracn_word_o, e);
              end
            end

    // R1 overwrite a slot
    dyn_mode_i = 1'b0; mode_pins_i = 2'd2; rmod_sel_i = 2'd0; refdiv_sel_i = 2'd2;
    write_word(2, 32'h0003_8000);
    tick(4);
    chk("R1 overwrite", eff_ratio_o, expect_eff(32'h0003_8000, 1'b0, 0, 2));

    // R11 latency: change modifier, eff due at edge 2, fracn at edge 3
    rmod_sel_i = 2'd1;
    tick(1);
    chk("R11 eff early", eff_ratio_o, expect_eff(words[2], 1'b0, 0, 2));
    tick(1);
    chk("R11 eff due", eff_ratio_o, expect_eff(words[2], 1'b0, 1, 2));
    chk("R11 fracn early", fracn_word_o, expect_eff(words[2], 1'b0, 0, 2));
    tick(1);
    chk("R11 fracn due", fracn_word_o, expect_eff(words[2], 1'b0, 1, 2));

    // R8 R9 source selection with reference absent
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++)
        for (int fm = 0; fm < 2; fm++) begin
          bit ed;
          manual_src_i = m[0]; src_dyn_bit_i = b[0]; force_manual_i = fm[0];
          tick(4);
          ed = (m == 1 || fm == 1) ? b[0] : 1'b0;
          chk("R8 R9 use_dyn absent", {63'd0, use_dynamic_o}, {63'd0, ed});
          chk("R8 R9 fracn absent", fracn_word_o, ed ? DPLL : eff_ratio_o);
        end

    // R10 presence
    manual_src_i = 1'b0; force_manual_i = 1'b0; src_dyn_bit_i = 1'b0;
    tick(2200);
    chk("R10 idle absent", {63'd0, ref_present_o}, 64'd0);
    ref_run = 1'b1;
    tick(2100);
    chk("R10 declared", {63'd0, ref_present_o}, 64'd1);
    tick(4);
    chk("R9 auto dynamic", {63'd0, use_dynamic_o}, 64'd1);
    chk("R9 auto fracn", fracn_word_o, DPLL);
    force_manual_i = 1'b1;
    tick(4);
    chk("R9 force manual", {63'd0, use_dynamic_o}, 64'd0);
    chk("R9 force fracn", fracn_word_o, eff_ratio_o);
    force_manual_i = 1'b0;
    ref_run = 1'b0;
    tick(1000);
    chk("R10 held one window", {63'd0, ref_present_o}, 64'd1);
    tick(2200);
    chk("R10 removed", {63'd0, ref_present_o}, 64'd0);
    tick(4);
    chk("R9 auto static", {63'd0, use_dynamic_o}, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule